// File: doc/BRIEF.md
# Serial Digital Potentiometer Controller

This block is the command engine behind a serial-controlled digital potentiometer pair. A host selects the device with an active-low chip select and clocks bytes in on a serial data line. The block holds one 8-bit wiper register per pot, which sets the wiper tap code. It also holds four data registers per pot, which stand in for nonvolatile storage. Read data returns on a serial output whose pad driver is enabled only while the device is selected.

Every frame opens with a device-select byte. Next comes an instruction byte, and after that, depending on the opcode, a data byte, no data at all, or an open run of SCK pulses that steps the wiper. Writes into data-register storage take effect only when chip select rises after a complete frame. A busy flag then covers a programmable number of clock cycles, and the host polls that flag with a status read. All serial inputs are resampled in the system clock domain, so SCK must be several system clocks slower than `clk_i`.

Top module: `pot_ctrl`

## Requirements
- R1: The first byte of every frame must equal the device code DEV_ID (default 0xA6). If it does not, the rest of the frame has no effect.
- R2: The instruction byte is [7:4] opcode, [3:2] data-register index, [1] pot index, [0] all-pots flag. Opcodes: 0x9 read wiper, 0xA write wiper, 0xB read data register, 0xC write data register, 0x5 read status, 0xD data register to wiper, 0xE wiper to data register, 0x2 step. The all-pots flag is ignored by every opcode except 0xD and 0xE.
- R3: Write wiper loads the byte that follows the instruction into the selected wiper register. The wiper_o field of that pot shows it WIPER_LAT clocks later. All wiper and data registers reset to 0.
- R4: For read commands, the byte after the instruction is answered on so_o, MSB first. Each bit changes after an SCK falling edge and is valid at the next SCK rising edge. Read status returns 0x01 when busy and 0x00 when idle.
- R5: Write data register commits its data byte only on the CS rise that ends a frame holding a whole number of bytes. A frame cut off mid-byte commits nothing and does not start the busy timer.
- R6: Each commit sets the busy flag for NV_CYCLES clocks. A status read issued during that time returns 0x01.
- R7: While busy, write wiper, write data register, both transfer commands and step are ignored. Read status still answers.
- R8: Data register to wiper copies the indexed data register of the selected pot into its wiper register as soon as the instruction byte ends. With the all-pots flag set, every pot loads from its own register at that index.
- R9: Wiper to data register copies the wiper value into the indexed data register (of one pot, or of all pots) at the closing CS rise, as a commit.
- R10: After a step instruction, each SCK rising edge moves the wiper up by one if SI is high and down by one if SI is low. It holds at 255 and at 0, and it stops when CS rises.
- R11: so_oe_o is 0 whenever the device is deselected and 1 while it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the so_o pad driver |
| wiper_o | output | 16 | Wiper codes, pot 0 in bits [7:0] |

## Verification
The assertions take for granted that SCK and CS change slowly enough for the input synchroniser to see every level, so that one SCK rise stays a single event. They also assume SCK never changes in the same system clock cycle as a CS edge. The bench holds each SCK half period at ten system clocks and keeps at least one half period between a CS edge and any SCK edge. Under those conditions, a step-mode SCK rise cannot be lost or doubled, and the saturation and busy-gating properties see clean events.

// File: rtl/pot_pkg.sv
`timescale 1ns/1ps
package pot_pkg;
  localparam int POTS  = 2;
  localparam int POT_W = 1;
  localparam int REGS  = 4;
  localparam int REG_W = 2;
  localparam int DW    = 8;

  typedef enum logic [3:0] {
    OP_STEP   = 4'h2,
    OP_RD_SR  = 4'h5,
    OP_RD_WCR = 4'h9,
    OP_WR_WCR = 4'hA,
    OP_RD_DR  = 4'hB,
    OP_WR_DR  = 4'hC,
    OP_DR2WCR = 4'hD,
    OP_WCR2DR = 4'hE
  } opcode_e;

  typedef enum logic [2:0] {
    PH_DEV, PH_INSTR, PH_DATA, PH_STEP, PH_IDLE
  } phase_e;
endpackage

// File: rtl/pot_spi_sync.sv
`timescale 1ns/1ps
module pot_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic sel_o,
  output logic cs_rise_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o
);
  localparam logic [2:0] IDLE_V = 3'b100;  // {cs, sck, si}

  logic [2:0] pipe_q [STAGES];
  logic [2:0] prev_q;
  logic [2:0] cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= IDLE_V;
    else         pipe_q[0] <= {cs_ni, sck_i, si_i};
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= IDLE_V;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign cur = pipe_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE_V;
    else         prev_q <= cur;
  end

  assign sel_o      = ~cur[2];
  assign cs_rise_o  = cur[2] & ~prev_q[2];
  assign sck_rise_o = ~cur[2] & cur[1] & ~prev_q[1];
  assign sck_fall_o = ~cur[2] & ~cur[1] & prev_q[1];
  assign si_o       = cur[0];
endmodule

// File: rtl/pot_nv_timer.sv
`timescale 1ns/1ps
module pot_nv_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_from_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/pot_wiper_delay.sv
`timescale 1ns/1ps
module pot_wiper_delay #(
  parameter int W   = 8,
  parameter int LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (LAT == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_pipe
    logic [W-1:0] st_q [LAT];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < LAT; i++) st_q[i] <= '0;
      end else begin
        st_q[0] <= d_i;
        for (int i = 1; i < LAT; i++) st_q[i] <= st_q[i-1];
      end
    end
    assign q_o = st_q[LAT-1];
  end
endmodule

// File: rtl/pot_ctrl.sv
`timescale 1ns/1ps
module pot_ctrl
  import pot_pkg::*;
#(
  parameter logic [7:0] DEV_ID      = 8'hA6,
  parameter int         NV_CYCLES   = 5000,
  parameter int         WIPER_LAT   = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [POTS*DW-1:0] wiper_o
);
  logic sel, cs_rise, sck_rise, sck_fall, si_s, busy, commit, byte_done;

  phase_e             phase_q;
  opcode_e            op_q;
  logic [2:0]         bit_q;
  logic [DW-2:0]      shin_q;
  logic [DW-1:0]      rx_byte, tx_q, nv_data_q;
  logic [REG_W-1:0]   reg_q;
  logic [POT_W-1:0]   pot_q;
  logic               glob_q, arm_q, arm_wcr_q, so_q;
  logic [DW-1:0]      wcr_q [POTS];
  logic [DW-1:0]      dr_q  [POTS][REGS];

  pot_spi_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .sel_o(sel), .cs_rise_o(cs_rise), .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall), .si_o(si_s)
  );

  pot_nv_timer #(.CYCLES(NV_CYCLES)) i_nv (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy)
  );

  assign rx_byte   = {shin_q, si_s};
  assign byte_done = sck_rise && (bit_q == 3'd7);
  // commit only on a byte-aligned frame end
  assign commit    = cs_rise && arm_q && (bit_q == 3'd0) && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_DEV;
      op_q      <= OP_RD_SR;
      bit_q     <= '0;
      shin_q    <= '0;
      reg_q     <= '0;
      pot_q     <= '0;
      glob_q    <= 1'b0;
      arm_q     <= 1'b0;
      arm_wcr_q <= 1'b0;
      nv_data_q <= '0;
      tx_q      <= '0;
      so_q      <= 1'b0;
      for (int k = 0; k < POTS; k++) begin
        wcr_q[k] <= '0;
        for (int r = 0; r < REGS; r++) dr_q[k][r] <= '0;
      end
    end else begin
      if (sck_fall) begin
        so_q <= tx_q[DW-1];
        tx_q <= {tx_q[DW-2:0], 1'b0};
      end

      if (commit) begin
        for (int k = 0; k < POTS; k++)
          for (int r = 0; r < REGS; r++)
            if ((pot_q == POT_W'(k) || (arm_wcr_q && glob_q)) && reg_q == REG_W'(r))
              dr_q[k][r] <= arm_wcr_q ? wcr_q[k] : nv_data_q;
      end

      if (!sel) begin
        phase_q <= PH_DEV;
        bit_q   <= '0;
        arm_q   <= 1'b0;
      end else if (sck_rise) begin
        shin_q <= {shin_q[DW-3:0], si_s};
        bit_q  <= bit_q + 3'd1;
        if (phase_q == PH_STEP) begin
          if (si_s) begin
            if (wcr_q[pot_q] != '1) wcr_q[pot_q] <= wcr_q[pot_q] + DW'(1);
          end else begin
            if (wcr_q[pot_q] != '0) wcr_q[pot_q] <= wcr_q[pot_q] - DW'(1);
          end
        end else if (byte_done) begin
          unique case (phase_q)
            PH_DEV: phase_q <= (rx_byte == DEV_ID) ? PH_INSTR : PH_IDLE;
            PH_INSTR: begin
              op_q    <= opcode_e'(rx_byte[7:4]);
              reg_q   <= rx_byte[3:2];
              pot_q   <= rx_byte[1];
              glob_q  <= rx_byte[0];
              phase_q <= PH_IDLE;
              case (opcode_e'(rx_byte[7:4]))
                OP_RD_WCR: tx_q <= wcr_q[rx_byte[1]];
                OP_RD_DR:  tx_q <= dr_q[rx_byte[1]][rx_byte[3:2]];
                OP_RD_SR:  tx_q <= {{(DW-1){1'b0}}, busy};
                OP_WR_WCR, OP_WR_DR: if (!busy) phase_q <= PH_DATA;
                OP_STEP:   if (!busy) phase_q <= PH_STEP;
                OP_DR2WCR: if (!busy) begin
                  for (int k = 0; k < POTS; k++)
                    if (rx_byte[0] || rx_byte[1] == POT_W'(k))
                      wcr_q[k] <= dr_q[k][rx_byte[3:2]];
                end
                OP_WCR2DR: if (!busy) begin
                  arm_q     <= 1'b1;
                  arm_wcr_q <= 1'b1;
                end
                default: ;
              endcase
            end
            PH_DATA: begin
              phase_q <= PH_IDLE;
              if (op_q == OP_WR_WCR) begin
                wcr_q[pot_q] <= rx_byte;
              end else begin
                arm_q     <= 1'b1;
                arm_wcr_q <= 1'b0;
                nv_data_q <= rx_byte;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign so_o    = sel & so_q;
  assign so_oe_o = sel;

  for (genvar k = 0; k < POTS; k++) begin : g_pot
    pot_wiper_delay #(.W(DW), .LAT(WIPER_LAT)) i_dly (
      .clk_i, .rst_ni, .d_i(wcr_q[k]), .q_o(wiper_o[k*DW +: DW])
    );
    for (genvar r = 0; r < REGS; r++) begin : g_reg
      assert_dr_commit_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(dr_q[k][r]) |-> $past(cs_rise));
    end
  end

  assert_step_hold_top_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && sck_rise && phase_q == PH_STEP && si_s && wcr_q[pot_q] == '1)
      |=> wcr_q[pot_q] == '1);

  assert_step_hold_bottom_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && sck_rise && phase_q == PH_STEP && !si_s && wcr_q[pot_q] == '0)
      |=> wcr_q[pot_q] == '0);

  assert_busy_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && sel && byte_done && phase_q == PH_INSTR)
      |=> (!arm_q && phase_q != PH_DATA && phase_q != PH_STEP));
endmodule

// File: tb/test_pot_ctrl.sv
`timescale 1ns/1ps
module test_pot_ctrl;
  localparam int HALF = 200;
  localparam int NV   = 4000;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic [15:0] wiper;

  always #10 clk = ~clk;

  pot_ctrl #(.NV_CYCLES(NV)) i_pot_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .wiper_o(wiper)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] dev_sel = 8'hA6;
  logic [7:0] exp_q[$];
  string      req_q[$];
  logic [7:0] rx_last;
  event       rx_ev;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expectations as read bytes arrive
  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) check("scoreboard underflow", 16'(rx_last), 16'hxxxx);
    else check(req_q.pop_front(), 16'(rx_last), 16'(exp_q.pop_front()));
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      #HALF;
      rx[i] = so;
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
    end
  endtask

  task automatic begin_frame();
    cs_n = 1'b0;
    #HALF;
  endtask

  task automatic end_frame();
    #HALF;
    cs_n = 1'b1;
    #(4*HALF);
  endtask

  task automatic send_hdr(input logic [3:0] op, input logic [1:0] r, input logic p, input logic g);
    logic [7:0] d;
    xfer(dev_sel, d);
    xfer({op, r, p, g}, d);
  endtask

  task automatic wr(input logic [3:0] op, input logic [1:0] r, input logic p, input logic [7:0] v);
    logic [7:0] d;
    begin_frame();
    send_hdr(op, r, p, 1'b0);
    xfer(v, d);
    end_frame();
  endtask

  task automatic rd(input logic [3:0] op, input logic [1:0] r, input logic p, input logic g,
                    input logic [7:0] exp, input string req);
    logic [7:0] d;
    exp_q.push_back(exp);
    req_q.push_back(req);
    begin_frame();
    send_hdr(op, r, p, g);
    xfer(8'h00, d);
    rx_last = d;
    -> rx_ev;
    end_frame();
  endtask

  task automatic xfr(input logic [3:0] op, input logic [1:0] r, input logic p, input logic g);
    begin_frame();
    send_hdr(op, r, p, g);
    end_frame();
  endtask

  task automatic step(input logic p, input int n, input logic up);
    begin_frame();
    send_hdr(4'h2, 2'd0, p, 1'b0);
    for (int i = 0; i < n; i++) begin
      si = up;
      #HALF;
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
    end
    end_frame();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    #100 rst_n = 1'b1;
    #200;
    check("R3 reset wiper", wiper, 16'h0000);
    check("R11 idle oe", 16'(so_oe), 16'h0000);

    wr(4'hA, 2'd0, 1'b0, 8'h5A);
    check("R3 write wiper", wiper, 16'h005A);

    begin_frame();
    #HALF;
    check("R11 selected oe", 16'(so_oe), 16'h0001);
    end_frame();
    check("R11 deselected oe", 16'(so_oe), 16'h0000);
    rd(4'h9, 2'd0, 1'b0, 1'b0, 8'h5A, "R4 R2 read wiper");

    wr(4'hC, 2'd2, 1'b1, 8'hC3);
    rd(4'h5, 2'd0, 1'b0, 1'b0, 8'h01, "R6 busy status");
    #(NV*20 + 10000);
    rd(4'h5, 2'd0, 1'b0, 1'b0, 8'h00, "R6 idle status");
    rd(4'hB, 2'd2, 1'b1, 1'b0, 8'hC3, "R5 commit data");
    rd(4'hB, 2'd2, 1'b1, 1'b1, 8'hC3, "R2 flag ignored on read");

    // aborted write: three extra bits after data byte
    begin_frame();
    send_hdr(4'hC, 2'd1, 1'b0, 1'b0);
    xfer(8'h77, d);
    for (int i = 0; i < 3; i++) begin
      #HALF; sck = 1'b1; #HALF; sck = 1'b0;
    end
    end_frame();
    rd(4'h5, 2'd0, 1'b0, 1'b0, 8'h00, "R5 abort no busy");
    rd(4'hB, 2'd1, 1'b0, 1'b0, 8'h00, "R5 abort no commit");

    dev_sel = 8'h00;
    wr(4'hA, 2'd0, 1'b0, 8'h99);
    dev_sel = 8'hA6;
    check("R1 wrong device", wiper, 16'h005A);
    rd(4'h9, 2'd0, 1'b0, 1'b0, 8'h5A, "R1 wiper kept");

    xfr(4'hD, 2'd2, 1'b1, 1'b0);
    check("R8 single load", wiper, 16'hC35A);

    wr(4'hA, 2'd0, 1'b0, 8'h33);
    wr(4'hA, 2'd0, 1'b1, 8'h44);
    check("R3 both wipers", wiper, 16'h4433);
    xfr(4'hD, 2'd2, 1'b0, 1'b1);
    check("R8 global load", wiper, 16'hC300);

    wr(4'hA, 2'd0, 1'b0, 8'hFD);
    step(1'b0, 5, 1'b1);
    check("R10 up saturates", wiper, 16'hC3FF);
    step(1'b0, 3, 1'b0);
    check("R10 down", wiper, 16'hC3FC);
    wr(4'hA, 2'd0, 1'b1, 8'h01);
    step(1'b1, 3, 1'b0);
    check("R10 down saturates", wiper, 16'h00FC);
    step(1'b1, 1, 1'b1);
    check("R10 up", wiper, 16'h01FC);

    xfr(4'hE, 2'd3, 1'b0, 1'b0);
    rd(4'h5, 2'd0, 1'b0, 1'b0, 8'h01, "R9 R6 store busy");
    wr(4'hA, 2'd0, 1'b0, 8'h11);
    check("R7 write ignored", wiper, 16'h01FC);
    step(1'b0, 2, 1'b1);
    check("R7 step ignored", wiper, 16'h01FC);
    rd(4'h5, 2'd0, 1'b0, 1'b0, 8'h01, "R7 status while busy");
    #(NV*20 + 10000);
    rd(4'hB, 2'd3, 1'b0, 1'b0, 8'hFC, "R9 single store");
    rd(4'hB, 2'd3, 1'b1, 1'b0, 8'h00, "R9 other pot untouched");

    xfr(4'hE, 2'd0, 1'b0, 1'b1);
    #(NV*20 + 10000);
    rd(4'hB, 2'd0, 1'b0, 1'b0, 8'hFC, "R9 global pot0");
    rd(4'hB, 2'd0, 1'b1, 1'b0, 8'h01, "R9 global pot1");
    rd(4'h5, 2'd0, 1'b0, 1'b0, 8'h00, "R6 idle at end");

    #1000;
    finish_run();
  end
endmodule